// File: doc/BRIEF.md
# Clock Gate Controller with Owner Select and Protected Writes

This block controls the enable of one gated clock. One control register picks who owns the gate. When software owns it, a software enable bit turns the clock on or off. When hardware owns it, the `hw_req_i` input does. The clock-enable output changes only after a settling delay. The same state is readable as a status bit, so software can poll for the gate to take effect. An optional turn-off hysteresis stretches the delay before the clock stops, with a short or a long length. A turn-on request during that window cancels the pending turn-off.

All control-register writes are locked behind a separate lock register. A write to the lock register counts only when it carries a fixed key. A build-time option gives a gate that cannot be turned off by software.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset the lock is closed, every control field is 0, and both `clk_en_o` and the status bit are 0.
- R2: A write to offset 0x0 whose bits 31:1 equal those of 0x00A5A500 sets the lock to open when bit 0 is 1 and closes it when bit 0 is 0. Offset 0x0 reads back the open flag in bit 0, with all other bits 0.
- R3: A write to offset 0x0 with any other value in bits 31:1 leaves the lock state unchanged.
- R4: A write to the control register at offset 0x4 while the lock is closed is dropped, and the register keeps its previous contents.
- R5: Control register layout at offset 0x4: bit 0 is the software enable, bit 1 is the owner select (1 = software, 0 = hardware), bit 2 is the hysteresis enable, bit 3 is the hysteresis length (0 = short, 1 = long), and bit 4 is the read-only status. The other bits read 0.
- R6: When the owner select is 0, the requested gate state is `hw_req_i`, and the software enable bit has no effect.
- R7: When the owner select is 1, the requested gate state is the software enable bit.
- R8: `clk_en_o` and the status bit take the requested state once it has differed from them on 4 consecutive clock edges when turning on.
- R9: Turn-off takes 4 consecutive differing edges without hysteresis, 16 with short hysteresis and 64 with long hysteresis.
- R10: With the no-disable option set and the owner select at 1, the requested state is on, whatever is written to the enable bit.
- R11: If the requested state returns to on while a turn-off is still pending, the pending turn-off is cancelled, and `clk_en_o` and the status bit stay 1.
- R12: The status bit at offset 0x4 bit 4 always equals `clk_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset, shared by read and write |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data for `addr_i` |
| hw_req_i | input | 1 | Hardware gate request, used when hardware owns the gate |
| clk_en_o | output | 1 | Clock enable, the settled gate state |

## Verification
The assertions assume that `hw_req_i` and the register inputs are stable around the rising edge. They also assume that the write strobe is a single-cycle pulse with address and data valid in the same cycle. The bench changes all inputs at the falling edge, so the sampled values are always settled. The random phase holds `hw_req_i` and the control fields for long enough runs that the 64-cycle turn-off window often completes. It also writes often enough that cancellations, locked writes and wrong keys all occur. Directed steps cover the exact delay boundaries, the cancellation and the no-disable build.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h00A5A500;

  typedef struct packed {
    logic hyst_long;
    logic hyst_en;
    logic sw_own;
    logic sw_on;
  } cg_ctrl_t;

  localparam int unsigned CTRL_W = $bits(cg_ctrl_t);
endpackage

// File: rtl/cg_wr_lock.sv
module cg_wr_lock
  import cg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] LOCK_OFF = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o
);
  logic hit, key_ok;
  assign hit    = wr_en_i && (addr_i == LOCK_OFF);
  assign key_ok = (wdata_i[DATA_W-1:1] == UNLOCK_KEY[DATA_W-1:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            unlocked_o <= 1'b0;
    else if (hit && key_ok) unlocked_o <= wdata_i[0];
  end

  // R3: a keyless write leaves the lock untouched
  a_r3_bad_key_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == LOCK_OFF && wdata_i[DATA_W-1:1] != UNLOCK_KEY[DATA_W-1:1])
      |=> $stable(unlocked_o));
endmodule

// File: rtl/cg_ctrl_reg.sv
module cg_ctrl_reg
  import cg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              unlocked_i,
  output cg_ctrl_t          ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else if (wr_en_i && addr_i == CTRL_OFF && unlocked_i) ctrl_o <= cg_ctrl_t'(wdata_i);
  end

  // R4: locked writes are dropped
  a_r4_locked_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == CTRL_OFF && !unlocked_i) |=> $stable(ctrl_o));
endmodule

// File: rtl/cg_gate_timer.sv
module cg_gate_timer #(
  parameter int unsigned ON_DLY     = 4,
  parameter int unsigned OFF_DLY    = 4,
  parameter int unsigned HYST_SHORT = 16,
  parameter int unsigned HYST_LONG  = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic hyst_en_i,
  input  logic hyst_long_i,
  output logic state_o
);
  localparam int unsigned MAX_A = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
  localparam int unsigned MAX_B = (HYST_SHORT > HYST_LONG) ? HYST_SHORT : HYST_LONG;
  localparam int unsigned MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = $clog2(MAX_D + 1);

  logic [CNT_W-1:0] cnt_q, lim;

  always_comb begin
    if (req_i)          lim = CNT_W'(ON_DLY - 1);
    else if (!hyst_en_i) lim = CNT_W'(OFF_DLY - 1);
    else if (hyst_long_i) lim = CNT_W'(HYST_LONG - 1);
    else                lim = CNT_W'(HYST_SHORT - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= 1'b0;
      cnt_q   <= '0;
    end else if (req_i != state_o) begin
      if (cnt_q >= lim) begin
        state_o <= req_i;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;  // request matches: any pending change is cancelled
    end
  end

  // R8/R9: the state only moves toward a request that differed before the edge
  a_r8_change_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_o) |-> ($past(req_i) != $past(state_o)));
  // R11: a matching request holds the state
  a_r11_match_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == state_o) |=> $stable(state_o));
  // R9: the counter stays within the longest window
  a_r9_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_D));
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import cg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] LOCK_OFF = 8'h00,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h04,
  parameter bit          NO_DISABLE = 1'b0,
  parameter int unsigned ON_DLY     = 4,
  parameter int unsigned OFF_DLY    = 4,
  parameter int unsigned HYST_SHORT = 16,
  parameter int unsigned HYST_LONG  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rd_data_o,
  input  logic              hw_req_i,
  output logic              clk_en_o
);
  logic     unlocked, req, state;
  cg_ctrl_t ctrl;

  cg_wr_lock #(.ADDR_W(ADDR_W), .LOCK_OFF(LOCK_OFF)) i_lock (
    .clk_i, .rst_ni, .wr_en_i, .addr_i,
    .wdata_i   (wdata_i),
    .unlocked_o(unlocked)
  );

  cg_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF)) i_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .addr_i,
    .wdata_i   (wdata_i[CTRL_W-1:0]),
    .unlocked_i(unlocked),
    .ctrl_o    (ctrl)
  );

  generate
    if (NO_DISABLE) begin : g_nodis
      assign req = ctrl.sw_own ? 1'b1 : hw_req_i;
    end else begin : g_norm
      assign req = ctrl.sw_own ? ctrl.sw_on : hw_req_i;
    end
  endgenerate

  cg_gate_timer #(
    .ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY), .HYST_SHORT(HYST_SHORT), .HYST_LONG(HYST_LONG)
  ) i_timer (
    .clk_i, .rst_ni,
    .req_i      (req),
    .hyst_en_i  (ctrl.hyst_en),
    .hyst_long_i(ctrl.hyst_long),
    .state_o    (state)
  );

  assign clk_en_o = state;

  always_comb begin
    rd_data_o = '0;
    if (addr_i == LOCK_OFF)      rd_data_o[0] = unlocked;
    else if (addr_i == CTRL_OFF) rd_data_o[CTRL_W:0] = {state, ctrl};
  end

  // R6: in hardware ownership, a steady low request never turns the gate on
  a_r6_hw_low_stays_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.sw_own && !hw_req_i && !clk_en_o) |=> !clk_en_o);
endmodule

// File: tb/test_clk_gate_ctrl.sv
`timescale 1ns/1ps
module test_clk_gate_ctrl;
  localparam logic [31:0] KEY = 32'h00A5A500;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, hw_req = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd0, rd1;
  logic        en0, en1;

  int unsigned n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  clk_gate_ctrl i_clk_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rd_data_o(rd0), .hw_req_i(hw_req), .clk_en_o(en0));

  clk_gate_ctrl #(.NO_DISABLE(1'b1)) i_clk_gate_ctrl_nd (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rd_data_o(rd1), .hw_req_i(hw_req), .clk_en_o(en1));

  // reference model, index 1 is the no-disable build
  logic       m_unl;
  logic [3:0] m_ctrl;
  logic       m_st [2];
  int         m_cnt [2];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(int i, logic [7:0] a);
    if (a == 8'h00) return {31'b0, m_unl};
    if (a == 8'h04) return {27'b0, m_st[i], m_ctrl};
    return 32'b0;
  endfunction

  task automatic m_edge(logic w, logic [7:0] a, logic [31:0] d, logic h);
    logic unl_pre = m_unl;
    for (int i = 0; i < 2; i++) begin
      logic req;
      int   dly;
      req = m_ctrl[1] ? (m_ctrl[0] | (i == 1)) : h;
      dly = req ? 4 : (!m_ctrl[2] ? 4 : (m_ctrl[3] ? 64 : 16));
      if (req != m_st[i]) begin
        if (m_cnt[i] >= dly - 1) begin m_st[i] = req; m_cnt[i] = 0; end
        else m_cnt[i]++;
      end else m_cnt[i] = 0;
    end
    if (w && a == 8'h00 && d[31:1] == KEY[31:1]) m_unl = d[0];
    if (w && a == 8'h04 && unl_pre) m_ctrl = d[3:0];
  endtask

  // drive after a falling edge, model at the rising edge, compare at the next falling edge
  task automatic step(logic w, logic [7:0] a, logic [31:0] d, logic h, string tag);
    wr_en = w; addr = a; wdata = d; hw_req = h;
    @(posedge clk);
    m_edge(w, a, d, h);
    @(negedge clk);
    wr_en = 1'b0;
    chk({tag, " en"}, {31'b0, en0}, {31'b0, m_st[0]});
    chk({tag, " en_nd"}, {31'b0, en1}, {31'b0, m_st[1]});
    chk({tag, " rd"}, rd0, m_read(0, a));
    chk({tag, " rd_nd"}, rd1, m_read(1, a));
  endtask

  logic cur_hw = 1'b0;
  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) step(1'b0, 8'h04, 32'h0, cur_hw, tag);
  endtask
  task automatic wr_ctrl(logic [31:0] v, string tag);
    step(1'b1, 8'h04, v, cur_hw, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_unl = 1'b0; m_ctrl = '0;
    for (int i = 0; i < 2; i++) begin m_st[i] = 1'b0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 en", {31'b0, en0}, 32'h0);
    addr = 8'h04; #1;
    chk("R1 ctrl", rd0, 32'h0);
    addr = 8'h00; #1;
    chk("R1 lock", rd0, 32'h0);

    // R4 locked write dropped
    wr_ctrl(32'h3, "R4");
    idle(1, "R4");
    chk("R4 ctrl", rd0, 32'h0);
    // R3 wrong key
    step(1'b1, 8'h00, 32'h00A5A401, 1'b0, "R3");
    step(1'b1, 8'h00, 32'h00A5A503, 1'b0, "R3");
    chk("R3 lock", rd0, 32'h0);
    // R2 unlock
    step(1'b1, 8'h00, KEY | 32'h1, 1'b0, "R2");
    chk("R2 open", rd0, 32'h1);

    // R6 hardware owns: sw_on set but hw_req low
    wr_ctrl(32'h1, "R6");
    idle(10, "R6");
    chk("R6 off", {31'b0, en0}, 32'h0);
    chk("R6 nd off", {31'b0, en1}, 32'h0);
    // R8 hw turn-on: 4 edges
    cur_hw = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      idle(1, "R8");
      chk("R8 hw on", {31'b0, en0}, (k == 4) ? 32'h1 : 32'h0);
    end
    // R6 hardware drops: sw_on still 1 but gate goes off after 4
    cur_hw = 1'b0;
    idle(4, "R6");
    chk("R6 hw off", {31'b0, en0}, 32'h0);

    // R7 software owns, turn on via write
    wr_ctrl(32'h3, "R7");
    for (int k = 1; k <= 4; k++) begin
      idle(1, "R7");
      chk("R7 sw on", {31'b0, en0}, (k == 4) ? 32'h1 : 32'h0);
    end
    // R9 no hysteresis off, R10 no-disable stays on
    wr_ctrl(32'h2, "R9");
    for (int k = 1; k <= 4; k++) begin
      idle(1, "R9");
      chk("R9 off4", {31'b0, en0}, (k == 4) ? 32'h0 : 32'h1);
    end
    idle(70, "R10");
    chk("R10 nd on", {31'b0, en1}, 32'h1);
    chk("R12 status", rd1, 32'h12);

    // R9 short hysteresis
    wr_ctrl(32'h7, "R9");
    idle(4, "R9");
    wr_ctrl(32'h6, "R9");
    for (int k = 1; k <= 16; k++) begin
      idle(1, "R9");
      if (k >= 15) chk("R9 off16", {31'b0, en0}, (k == 16) ? 32'h0 : 32'h1);
    end
    // R9 long hysteresis
    wr_ctrl(32'hF, "R9");
    idle(4, "R9");
    wr_ctrl(32'hE, "R9");
    for (int k = 1; k <= 64; k++) begin
      idle(1, "R9");
      if (k >= 63) chk("R9 off64", {31'b0, en0}, (k == 64) ? 32'h0 : 32'h1);
    end

    // R11 cancel a pending turn-off
    wr_ctrl(32'hF, "R11");
    idle(4, "R11");
    wr_ctrl(32'hE, "R11");
    idle(20, "R11");
    wr_ctrl(32'hF, "R11");
    for (int k = 0; k < 80; k++) begin
      idle(1, "R11");
      chk("R11 held", {31'b0, en0}, 32'h1);
      chk("R12 status", {31'b0, rd0[4]}, {31'b0, en0});
    end

    // R2 relock, then a control write is dropped
    step(1'b1, 8'h00, KEY, 1'b0, "R2");
    chk("R2 closed", rd0, 32'h0);
    wr_ctrl(32'h0, "R4");
    idle(1, "R4");
    chk("R4 kept", rd0[3:0], 32'hF);

    // random phase, R5 layout checked through the model
    for (int n = 0; n < 1600; n++) begin
      int unsigned r = $urandom_range(0, 99);
      if (r < 3) cur_hw = ~cur_hw;
      if (r < 6)
        step(1'b1, 8'h00, KEY | 32'($urandom_range(0, 1)), cur_hw, "R2");
      else if (r < 8)
        step(1'b1, 8'h00, $urandom(), cur_hw, "R3");
      else if (r < 12)
        step(1'b1, 8'h04, $urandom(), cur_hw, "R5");
      else
        step(1'b0, ($urandom_range(0, 1) == 0) ? 8'h00 : 8'h04, 32'h0, cur_hw, "R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule